// File: doc/BRIEF.md
# Counter and Edge Interrupt Controller

This block merges two interrupt sources into one request and one handler entry point, which sits at vector address 0. The first source is an 8-bit up counter that advances on every clock and raises its cause when it rolls over from 255 to 0. The second source is a bank of port pins. Each pin has an edge detector with its own polarity select and enable bit, and a sticky pending bit that software reads and clears.

When a cause is seen while the block is idle, an entry sequence starts. After a fixed number of clocks, `entry_o` pulses and the block is in service. While in service, pin edges are only recorded. A counter rollover during service starts no entry; it is visible only through the overflow flag, so the handler has to poll for it.

Service ends with a return. A plain return leaves the counter running untouched. A return with adjust adds a signed offset to the live count, so a periodic tick keeps its interval whatever the handler's length. Entering service for a pin edge never disturbs the counter. If an enabled pending bit is still set when the handler returns, the entry sequence starts again on the next clock.

Top module: `tick_edge_irq`

## Requirements
- R1: With no load and no return-with-adjust, `cnt_o` increases by exactly 1 each clock. It wraps from 255 to 0. Reset clears it to 0.
- R2: `ovf_o` sets on the clock where `cnt_o` turns from 255 to 0 by counting, whether or not the block is in service. It stays set until a cycle with `ovf_clr_i`=1 clears it. A set in the same cycle wins over the clear.
- R3: A rollover while idle starts entry. `in_svc_o` rises exactly 3 clocks after the first cycle that shows `cnt_o`=0. `entry_o` is high only in the first service cycle.
- R4: A rollover during the entry sequence or during service starts no entry. After a plain return, that rollover causes no later entry.
- R5: Entry caused by a pin edge does not clear, load or stall the counter. It keeps adding 1 per clock through entry and service.
- R6: Pins pass through a two-flop synchronizer before edge detection. `edge_pol_i` bit 1 selects a rising edge and bit 0 selects a falling edge. `pend_o[i]` shows the selected edge 3 clocks after the pin changes. The opposite edge sets nothing.
- R7: A pending bit stays set until a cycle with the matching `pend_clr_i` bit at 1. A new edge in the same cycle wins over the clear.
- R8: A pending bit with its `edge_en_i` bit at 1 requests entry, with the same 3-clock latency as R3. A pending bit whose enable is 0 never causes entry.
- R9: A return with `ret_adj_i`=1 loads `cnt_o` with `cnt_o + ret_off_i` modulo 256, where `ret_off_i` is two's complement. There is no extra increment that clock, and it never sets `ovf_o`. For example, 50 plus -100 gives 206.
- R10: A plain return lets the counter take its normal +1 step. `cnt_wr_i` loads `cnt_wdata_i` on the next clock, and it has priority over both adjust and counting.
- R11: `ret_i` outside service has no effect: the counter keeps its +1 step and the service state does not change.
- R12: `in_svc_o` drops on the clock after a return. If an enabled pending bit is still set at the return, `in_svc_o` rises again 3 clocks after it dropped. Otherwise the block stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Asynchronous port pins watched for edges |
| edge_pol_i | input | 8 | Per-pin edge select, 1 = rising, 0 = falling |
| edge_en_i | input | 8 | Per-pin enable of the interrupt request |
| pend_clr_i | input | 8 | Per-pin pending clear, 1 clears |
| cnt_wr_i | input | 1 | Load the counter directly |
| cnt_wdata_i | input | 8 | Value for a direct counter load |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| ret_i | input | 1 | Return from service (one-cycle pulse) |
| ret_adj_i | input | 1 | With `ret_i`, add `ret_off_i` to the counter |
| ret_off_i | input | 8 | Signed counter offset for a return with adjust |
| cnt_o | output | 8 | Live counter value |
| ovf_o | output | 1 | Sticky rollover flag |
| pend_o | output | 8 | Sticky per-pin edge pending bits |
| in_svc_o | output | 1 | Handler is in service |
| entry_o | output | 1 | One-cycle pulse in the first handler cycle (vector 0) |

## Verification
The assertions assume that `ret_i`, `cnt_wr_i` and the clear inputs are clean synchronous pulses, and that pins start low out of reset, so the history flop of the synchronizer sees no false edge. The stimulus changes every input on the falling clock edge and holds each pin level for many clocks, so that every transition crosses the synchronizer. Before each test that is sensitive to the idle state, the bench loads the counter far from its rollover point. This way, a stray counter entry cannot mask or imitate an edge entry.

// File: rtl/tick_edge_irq_pkg.sv
package tick_edge_irq_pkg;

  // Service sequencer states
  typedef enum logic [1:0] {
    SVC_IDLE   = 2'd0,
    SVC_WAIT   = 2'd1,
    SVC_ACTIVE = 2'd2
  } svc_state_e;

endpackage

// File: rtl/tei_edge_bank.sv
module tei_edge_bank #(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] en_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] pend_o,
  output logic             req_o
);

  localparam int HIST_W = SYNC_STAGES + 1;

  logic [NPINS-1:0] pend_vec;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [HIST_W-1:0] sh_q;
    logic              cur, prev, hit;
    logic              pend_q;

    // synchronizer chain plus one history stage
    always_ff @(posedge clk) begin
      if (rst) sh_q <= '0;
      else     sh_q <= {sh_q[HIST_W-2:0], pin_i[g]};
    end

    assign cur  = sh_q[SYNC_STAGES-1];
    assign prev = sh_q[SYNC_STAGES];
    assign hit  = pol_i[g] ? (cur & ~prev) : (~cur & prev);

    always_ff @(posedge clk) begin
      if (rst)           pend_q <= 1'b0;
      else if (hit)      pend_q <= 1'b1;
      else if (clr_i[g]) pend_q <= 1'b0;
    end

    assign pend_vec[g] = pend_q;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
      (pend_q && !clr_i[g]) |=> pend_q) else $error("pending bit lost"); // R7
  end

  assign pend_o = pend_vec;
  assign req_o  = |(pend_vec & en_i);

endmodule

// File: rtl/tei_counter.sv
module tei_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             adj_i,
  input  logic [CNT_W-1:0] off_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q, ovf_q;
  logic             counting, rolls;

  assign counting = !wr_i && !adj_i;
  assign rolls    = counting && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= rolls;
      if (wr_i)       cnt_q <= wdata_i;
      else if (adj_i) cnt_q <= cnt_q + off_i;
      else            cnt_q <= cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            ovf_q <= 1'b0;
    else if (rolls)     ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;
  assign ovf_o  = ovf_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && !adj_i) |=> cnt_q == CNT_W'($past(cnt_q) + CNT_ONE))
    else $error("counter step wrong"); // R1
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> cnt_q == $past(wdata_i)) else $error("counter load wrong"); // R10
  AST_CNT_ADJ: assert property (@(posedge clk) disable iff (rst)
    (adj_i && !wr_i) |=> cnt_q == CNT_W'($past(cnt_q) + $past(off_i)))
    else $error("return adjust wrong"); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ovf_clr_i) |=> ovf_q) else $error("overflow flag lost"); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> (cnt_q == '0 && ovf_q)) else $error("wrap without zero"); // R2

endmodule

// File: rtl/tei_svc_ctrl.sv
module tei_svc_ctrl
  import tick_edge_irq_pkg::*;
#(
  parameter int ENTRY_LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tmr_cause_i,
  input  logic edge_cause_i,
  input  logic ret_i,
  output logic ret_ok_o,
  output logic in_svc_o,
  output logic entry_o
);

  localparam int             LAT_W    = $clog2(ENTRY_LAT + 1);
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(ENTRY_LAT - 1);
  localparam logic [LAT_W-1:0] LAT_ONE  = LAT_W'(1);

  svc_state_e       state_q;
  logic [LAT_W-1:0] lat_q;
  logic             entry_q;

  assign ret_ok_o = ret_i && (state_q == SVC_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SVC_IDLE;
      lat_q   <= '0;
      entry_q <= 1'b0;
    end else begin
      entry_q <= 1'b0;
      case (state_q)
        SVC_IDLE: begin
          if (tmr_cause_i || edge_cause_i) begin
            state_q <= SVC_WAIT;
            lat_q   <= LAT_ONE;
          end
        end
        SVC_WAIT: begin
          if (lat_q == LAT_LAST) begin
            state_q <= SVC_ACTIVE;
            entry_q <= 1'b1;
          end else begin
            lat_q <= lat_q + LAT_ONE;
          end
        end
        SVC_ACTIVE: begin
          if (ret_i) state_q <= SVC_IDLE;
        end
        default: state_q <= SVC_IDLE;
      endcase
    end
  end

  assign in_svc_o = (state_q == SVC_ACTIVE);
  assign entry_o  = entry_q;

  AST_NO_NESTED_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_q == SVC_ACTIVE) |=> state_q != SVC_WAIT) else $error("entry from service"); // R4
  AST_ENTRY_IN_SVC: assert property (@(posedge clk) disable iff (rst)
    entry_q |-> state_q == SVC_ACTIVE) else $error("entry outside service"); // R3
  AST_ENTRY_PULSE: assert property (@(posedge clk) disable iff (rst)
    entry_q |=> !entry_q) else $error("entry longer than a cycle"); // R3
  AST_RET_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == SVC_ACTIVE && ret_i) |=> state_q == SVC_IDLE) else $error("return not taken"); // R12
  AST_IDLE_RET_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state_q == SVC_WAIT && ret_i) |=> state_q != SVC_IDLE) else $error("return during entry"); // R11

endmodule

// File: rtl/tick_edge_irq.sv
module tick_edge_irq #(
  parameter int CNT_W       = 8,
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_LAT   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] edge_pol_i,
  input  logic [NPINS-1:0] edge_en_i,
  input  logic [NPINS-1:0] pend_clr_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             ovf_clr_i,
  input  logic             ret_i,
  input  logic             ret_adj_i,
  input  logic [CNT_W-1:0] ret_off_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic [NPINS-1:0] pend_o,
  output logic             in_svc_o,
  output logic             entry_o
);

  logic wrap, edge_req, ret_ok, adj;

  assign adj = ret_ok && ret_adj_i;

  tei_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (cnt_wr_i),
    .wdata_i   (cnt_wdata_i),
    .adj_i     (adj),
    .off_i     (ret_off_i),
    .ovf_clr_i (ovf_clr_i),
    .cnt_o     (cnt_o),
    .wrap_o    (wrap),
    .ovf_o     (ovf_o)
  );

  tei_edge_bank #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_i),
    .pol_i  (edge_pol_i),
    .en_i   (edge_en_i),
    .clr_i  (pend_clr_i),
    .pend_o (pend_o),
    .req_o  (edge_req)
  );

  tei_svc_ctrl #(.ENTRY_LAT(ENTRY_LAT)) u_svc (
    .clk          (clk),
    .rst          (rst),
    .tmr_cause_i  (wrap),
    .edge_cause_i (edge_req),
    .ret_i        (ret_i),
    .ret_ok_o     (ret_ok),
    .in_svc_o     (in_svc_o),
    .entry_o      (entry_o)
  );

  AST_EDGE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (entry_o && !cnt_wr_i && !adj) |=> cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1)))
    else $error("entry disturbed counter"); // R5

endmodule

// File: tb/tick_edge_irq_test.sv
`timescale 1ns/1ps
module tick_edge_irq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pin_i = '0, edge_pol_i = '0, edge_en_i = '0, pend_clr_i = '0;
  logic       cnt_wr_i = 1'b0, ovf_clr_i = 1'b0, ret_i = 1'b0, ret_adj_i = 1'b0;
  logic [7:0] cnt_wdata_i = '0, ret_off_i = '0;
  logic [7:0] cnt_o, pend_o;
  logic       ovf_o, in_svc_o, entry_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  tick_edge_irq uut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .edge_pol_i(edge_pol_i),
    .edge_en_i(edge_en_i), .pend_clr_i(pend_clr_i), .cnt_wr_i(cnt_wr_i),
    .cnt_wdata_i(cnt_wdata_i), .ovf_clr_i(ovf_clr_i), .ret_i(ret_i),
    .ret_adj_i(ret_adj_i), .ret_off_i(ret_off_i), .cnt_o(cnt_o), .ovf_o(ovf_o),
    .pend_o(pend_o), .in_svc_o(in_svc_o), .entry_o(entry_o)
  );

  // {loaded count, signed offset, expected count after adjust}
  localparam logic [23:0] ADJ_VEC [8] = '{
    {8'd50,  8'h9C, 8'd206},
    {8'd0,   8'h01, 8'd1},
    {8'd255, 8'h01, 8'd0},
    {8'd100, 8'h80, 8'd228},
    {8'd127, 8'h7F, 8'd254},
    {8'd200, 8'h38, 8'd0},
    {8'd10,  8'hF6, 8'd0},
    {8'd128, 8'h80, 8'd0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_cnt(input logic [7:0] v);
    cnt_wr_i = 1'b1; cnt_wdata_i = v;
    tick(1);
    cnt_wr_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] c;
    tick(3);
    // reset state
    chk("R1 reset count", cnt_o, 0);
    chk("R2 reset flag", ovf_o, 0);
    chk("R7 reset pending", pend_o, 0);
    chk("R12 reset service", in_svc_o, 0);
    chk("R3 reset entry", entry_o, 0);
    rst = 1'b0;
    tick(10);
    chk("R1 count after 10", cnt_o, 10);

    // rollover while idle
    load_cnt(8'd250);
    chk("R10 load", cnt_o, 250);
    tick(5);
    chk("R1 count 255", cnt_o, 255);
    chk("R2 flag before wrap", ovf_o, 0);
    tick(1);
    chk("R1 wrap to 0", cnt_o, 0);
    chk("R2 flag on wrap", ovf_o, 1);
    tick(2);
    chk("R3 not yet in service", in_svc_o, 0);
    tick(1);
    chk("R3 in service at 3", in_svc_o, 1);
    chk("R3 entry pulse", entry_o, 1);
    tick(1);
    chk("R3 entry one cycle", entry_o, 0);
    ovf_clr_i = 1'b1; tick(1); ovf_clr_i = 1'b0;
    chk("R2 flag cleared", ovf_o, 0);

    // rollover during service
    for (int k = 0; k < 300 && cnt_o != 8'd0; k++) tick(1);
    chk("R2 flag set in service", ovf_o, 1);
    tick(3);
    chk("R4 still in service", in_svc_o, 1);
    chk("R4 no entry pulse", entry_o, 0);
    c = cnt_o;
    ret_i = 1'b1; ret_adj_i = 1'b0;
    tick(1);
    ret_i = 1'b0;
    chk("R10 plain return step", cnt_o, 8'(c + 8'd1));
    chk("R12 left service", in_svc_o, 0);
    tick(5);
    chk("R4 dropped rollover", in_svc_o, 0);

    // return while idle
    c = cnt_o;
    ret_i = 1'b1; ret_adj_i = 1'b1; ret_off_i = 8'h9C;
    tick(1);
    ret_i = 1'b0; ret_adj_i = 1'b0;
    chk("R11 idle return count", cnt_o, 8'(c + 8'd1));
    tick(4);
    chk("R11 idle return service", in_svc_o, 0);

    // disabled rising edge on pin 0
    load_cnt(8'd10);
    edge_pol_i = 8'b0000_0101;
    pin_i[0] = 1'b1;
    tick(2);
    chk("R6 pend not before 3", pend_o[0], 0);
    tick(1);
    chk("R6 rising pend", pend_o[0], 1);
    tick(8);
    chk("R8 disabled no entry", in_svc_o, 0);
    chk("R7 pend held", pend_o[0], 1);
    pend_clr_i[0] = 1'b1; tick(1); pend_clr_i[0] = 1'b0;
    chk("R7 pend cleared", pend_o[0], 0);

    // falling select on pin 1
    pin_i[1] = 1'b1;
    tick(5);
    chk("R6 wrong edge ignored", pend_o[1], 0);
    pin_i[1] = 1'b0;
    tick(3);
    chk("R6 falling pend", pend_o[1], 1);
    pend_clr_i[1] = 1'b1; tick(1); pend_clr_i[1] = 1'b0;

    // enabled rising edge on pin 2
    load_cnt(8'd20);
    chk("R10 load 20", cnt_o, 20);
    edge_en_i[2] = 1'b1;
    pin_i[2] = 1'b1;
    tick(5);
    chk("R8 edge not yet in service", in_svc_o, 0);
    tick(1);
    chk("R8 edge entry", in_svc_o, 1);
    chk("R3 edge entry pulse", entry_o, 1);
    chk("R5 count through entry", cnt_o, 26);
    tick(4);
    chk("R5 count in service", cnt_o, 30);

    // return-with-adjust table; pin 2 stays pending so each return re-enters
    foreach (ADJ_VEC[i]) begin
      for (int k = 0; k < 20 && !in_svc_o; k++) tick(1);
      load_cnt(ADJ_VEC[i][23:16]);
      ret_i = 1'b1; ret_adj_i = 1'b1; ret_off_i = ADJ_VEC[i][15:8];
      tick(1);
      ret_i = 1'b0; ret_adj_i = 1'b0;
      chk("R9 adjusted count", cnt_o, ADJ_VEC[i][7:0]);
      chk("R12 drop on return", in_svc_o, 0);
      tick(2);
      chk("R12 not back yet", in_svc_o, 0);
      tick(1);
      chk("R12 re-entry", in_svc_o, 1);
      chk("R1 count after re-entry", cnt_o, 8'(ADJ_VEC[i][7:0] + 8'd3));
    end

    // clear and leave for good
    pend_clr_i[2] = 1'b1; tick(1); pend_clr_i[2] = 1'b0;
    chk("R7 pin 2 cleared", pend_o[2], 0);
    ret_i = 1'b1; tick(1); ret_i = 1'b0;
    chk("R12 left service", in_svc_o, 0);
    tick(6);
    chk("R12 stays idle", in_svc_o, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule